// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns internal requests (program fetch, data read, data write) into cycles on a multiplexed external bus with a 20-bit address. The shared byte-wide port carries the low address byte first and then the data byte. A second byte port carries address bits 15..8, and a 4-bit port carries bits 19..16. The block drives an address-latch strobe so that external logic can capture the low byte. It then drives one of three strobes: program read, data read or data write.

One period of `clk` stands for one half-period of the oscillator, so every phase length is a count of `clk` cycles. A program fetch below 64 KB is served internally when `int_rom_en` is high. When `int_rom_en` is low, every program address goes to the bus. A data access always places the program segment on the top address nibble. The `wait_in` pin can stretch data strobes one cycle at a time.

The internal side uses a simple handshake. The requester holds `req_valid` and the request fields until it sees a one-cycle `req_ack`. Fetch and read data come back with a one-cycle `rd_valid` in that same cycle.

Top module: `mxb_bus_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ale`, `prog_strb`, `rd_strb`, `wr_strb`, `ad_oe`, `req_ack`, `rd_valid`, `int_sel` and `bus_pin_own` are all 0.
- R2: A fetch (`req_kind`=2'b00) whose address bits 19..16 are zero, accepted while `int_rom_en`=1, makes no bus activity. In the cycle after acceptance, `req_ack` and `int_sel` are both 1 for one cycle.
- R3: A fetch goes to the external bus when its address is 0x10000 or above, or when `int_rom_en`=0 (at any address). It produces exactly two cycles of `prog_strb`.
- R4: Count the cycles after the accepting edge as 1, 2, 3 and so on. From cycle 1 until the access ends, `addr_mid` = address bits 15..8 and `addr_hi` carries the top nibble. `ale` is high in cycles 3 and 4. `ad_out` holds address bits 7..0 with `ad_oe`=1 in cycles 3 to 5.
- R5: The strobe starts in cycle 6 and lasts two cycles when not stretched. The kind selects the strobe: `prog_strb` for 2'b00, `rd_strb` for 2'b01 or 2'b11, and `wr_strb` for 2'b10. At most one strobe is high at a time, and never together with `ale`.
- R6: `ad_oe` is 0 outside an access, during the fetch or read strobe, and in the cycle after it. It is 1 only during the address phase and the write data phase.
- R7: For a write, `ad_out` = `req_wdata` with `ad_oe`=1 throughout the `wr_strb` cycles and for one more cycle after `wr_strb` falls.
- R8: For a fetch or read, `ad_in` is sampled at the edge that ends the strobe. In the next cycle, `rd_data` carries that byte, and `rd_valid` and `req_ack` are both 1. A write gives `req_ack` with `rd_valid`=0.
- R9: For a data read or write, `addr_hi` = `prog_seg` and request address bits 19..16 are ignored. For a fetch, `addr_hi` = address bits 19..16.
- R10: `wait_in` passes through a two-flop synchronizer. At each edge where a data strobe would end, a synchronized 1 keeps the strobe one more cycle. Fetch strobes are never stretched.
- R11: `bus_pin_own` equals `port_bus_cfg | ~int_rom_en` one cycle after those inputs, so the bus pins are forced to their bus function whenever `int_rom_en` is 0.
- R12: One access runs at a time. `req_ack` is a single-cycle pulse, and the next request is accepted in the first idle cycle after the ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per oscillator half-period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending, held until `req_ack` |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 8 | Write data |
| prog_seg | input | 4 | Program segment placed on `addr_hi` for data cycles |
| int_rom_en | input | 1 | 1: fetches below 64 KB are internal; 0: all fetches external |
| port_bus_cfg | input | 1 | Port configuration asking for bus function |
| req_ack | output | 1 | One-cycle completion pulse |
| int_sel | output | 1 | Fetch served by internal memory |
| rd_valid | output | 1 | `rd_data` valid |
| rd_data | output | 8 | Returned fetch or read byte |
| ad_out | output | 8 | Shared low-address/data byte, output value |
| ad_oe | output | 1 | Output enable for the shared byte |
| ad_in | input | 8 | Shared byte, input value |
| addr_mid | output | 8 | Address bits 15..8 |
| addr_hi | output | 4 | Address bits 19..16 or program segment |
| ale | output | 1 | Address-latch strobe |
| prog_strb | output | 1 | Program read strobe, active high |
| rd_strb | output | 1 | Data read strobe, active high |
| wr_strb | output | 1 | Data write strobe, active high |
| wait_in | input | 1 | Asynchronous wait request |
| bus_pin_own | output | 1 | Upper address pins and strobes in bus function |

## Verification
Each output has a fixed due cycle, counted from the edge that accepts a request: the upper address from cycle 1, `ale` in cycles 3 to 4, the strobe from cycle 6, and `req_ack` with `rd_valid` in the cycle after the strobe. An internal fetch acks in cycle 1, and `bus_pin_own` follows its inputs one cycle later. The bench keeps a phase counter for each access, advanced at every rising edge. It compares every output a quarter period after the edge, so each value is checked in the exact cycle it is due. A wait stretch is predicted from the `wait_in` values sampled two edges before the decision edge, which follows the synchronizer delay.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b10;

  typedef enum logic [2:0] {
    PH_IDLE, PH_INT, PH_UPPER, PH_LATCH, PH_HOLD, PH_STROBE, PH_TAIL
  } phase_t;
endpackage

// File: rtl/mxb_wait_sync.sv
module mxb_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mxb_decode.sv
module mxb_decode #(
  parameter int ADDR_W  = 20,
  parameter int LOCAL_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic [1:0]                kind,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-LOCAL_W-1:0] seg,
  input  logic                      int_rom_en,
  output logic                      is_internal,
  output logic [ADDR_W-LOCAL_W-1:0] hi,
  output logic [LOCAL_W-DATA_W-1:0] mid,
  output logic [DATA_W-1:0]         lo
);
  import mxb_pkg::*;
  logic fetch;

  always_comb begin
    fetch       = (kind == KIND_FETCH);
    is_internal = fetch && int_rom_en && (addr[ADDR_W-1:LOCAL_W] == '0);
    hi          = fetch ? addr[ADDR_W-1:LOCAL_W] : seg;
    mid         = addr[LOCAL_W-1:DATA_W];
    lo          = addr[DATA_W-1:0];
  end
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq #(
  parameter int DATA_W  = 8,
  parameter int MID_W   = 8,
  parameter int HI_W    = 4,
  parameter int LEAD_HP = 2,
  parameter int ALE_HP  = 2,
  parameter int STB_HP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              is_internal,
  input  logic [HI_W-1:0]   hi,
  input  logic [MID_W-1:0]  mid,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wait_sync,
  input  logic [DATA_W-1:0] ad_in,
  output logic              req_ack,
  output logic              int_sel,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ale,
  output logic              prog_strb,
  output logic              rd_strb,
  output logic              wr_strb,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [MID_W-1:0]  a_mid,
  output logic [HI_W-1:0]   a_hi
);
  import mxb_pkg::*;
  localparam int MAX_HP = (LEAD_HP > ALE_HP) ? ((LEAD_HP > STB_HP) ? LEAD_HP : STB_HP)
                                             : ((ALE_HP > STB_HP) ? ALE_HP : STB_HP);
  localparam int CNT_W  = $clog2(MAX_HP + 1);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        kind_q;
  logic [DATA_W-1:0] lo_q, wd_q;
  logic              is_fetch_q, is_write_q;

  assign is_fetch_q = (kind_q == KIND_FETCH);
  assign is_write_q = (kind_q == KIND_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; kind_q <= KIND_FETCH;
      lo_q <= '0; wd_q <= '0; rd_data <= '0;
      req_ack <= 1'b0; int_sel <= 1'b0; rd_valid <= 1'b0;
      ale <= 1'b0; prog_strb <= 1'b0; rd_strb <= 1'b0; wr_strb <= 1'b0;
      ad_out <= '0; ad_oe <= 1'b0; a_mid <= '0; a_hi <= '0;
    end else begin
      req_ack  <= 1'b0;
      int_sel  <= 1'b0;
      rd_valid <= 1'b0;
      case (ph)
        PH_IDLE: if (req_valid) begin
          if (is_internal) begin
            ph <= PH_INT; req_ack <= 1'b1; int_sel <= 1'b1;
          end else begin
            ph <= PH_UPPER; cnt <= '0;
            kind_q <= req_kind; lo_q <= lo; wd_q <= wdata;
            a_mid <= mid; a_hi <= hi;
          end
        end
        PH_INT: ph <= PH_IDLE;
        PH_UPPER: begin
          if (cnt == CNT_W'(LEAD_HP - 1)) begin
            ph <= PH_LATCH; cnt <= '0;
            ale <= 1'b1; ad_out <= lo_q; ad_oe <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        PH_LATCH: begin
          if (cnt == CNT_W'(ALE_HP - 1)) begin
            ph <= PH_HOLD; cnt <= '0; ale <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        PH_HOLD: begin
          ph <= PH_STROBE; cnt <= '0;
          prog_strb <= is_fetch_q;
          wr_strb   <= is_write_q;
          rd_strb   <= !is_fetch_q && !is_write_q;
          ad_oe     <= is_write_q;
          ad_out    <= wd_q;
        end
        PH_STROBE: begin
          if (cnt == CNT_W'(STB_HP - 1)) begin
            if (!(wait_sync && !is_fetch_q)) begin
              ph <= PH_TAIL;
              prog_strb <= 1'b0; rd_strb <= 1'b0; wr_strb <= 1'b0;
              req_ack  <= 1'b1;
              rd_valid <= !is_write_q;
              if (!is_write_q) rd_data <= ad_in;
            end
          end else cnt <= cnt + 1'b1;
        end
        PH_TAIL: begin
          ph <= PH_IDLE; ad_oe <= 1'b0;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R5: never two strobes at once
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_strb, rd_strb, wr_strb}));
  // R5: latch strobe and access strobes are apart
  a_r5_ale_apart: assert property (@(posedge clk) disable iff (rst)
    !(ale && (prog_strb || rd_strb || wr_strb)));
  // R6: shared byte released while the outside drives it
  a_r6_bus_turn: assert property (@(posedge clk) disable iff (rst)
    (prog_strb || rd_strb) |-> !ad_oe);
  // R4: a strobe follows one cycle after the latch strobe falls
  a_r4_strobe_after_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |=> (prog_strb || rd_strb || wr_strb));
  // R8: returned data comes with the ack
  a_r8_valid_with_ack: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> req_ack);
endmodule

// File: rtl/mxb_bus_ctrl.sv
module mxb_bus_ctrl #(
  parameter int ADDR_W      = 20,
  parameter int LOCAL_W     = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_HP     = 2,
  parameter int ALE_HP      = 2,
  parameter int STB_HP      = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [1:0]                req_kind,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic [ADDR_W-LOCAL_W-1:0] prog_seg,
  input  logic                      int_rom_en,
  input  logic                      port_bus_cfg,
  output logic                      req_ack,
  output logic                      int_sel,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic [DATA_W-1:0]         ad_out,
  output logic                      ad_oe,
  input  logic [DATA_W-1:0]         ad_in,
  output logic [LOCAL_W-DATA_W-1:0] addr_mid,
  output logic [ADDR_W-LOCAL_W-1:0] addr_hi,
  output logic                      ale,
  output logic                      prog_strb,
  output logic                      rd_strb,
  output logic                      wr_strb,
  input  logic                      wait_in,
  output logic                      bus_pin_own
);
  localparam int HI_W  = ADDR_W - LOCAL_W;
  localparam int MID_W = LOCAL_W - DATA_W;

  logic              is_internal, wait_sync;
  logic [HI_W-1:0]   hi;
  logic [MID_W-1:0]  mid;
  logic [DATA_W-1:0] lo;

  mxb_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(wait_in), .sync_out(wait_sync));

  mxb_decode #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .DATA_W(DATA_W)) u_dec (
    .kind(req_kind), .addr(req_addr), .seg(prog_seg), .int_rom_en(int_rom_en),
    .is_internal(is_internal), .hi(hi), .mid(mid), .lo(lo));

  mxb_seq #(.DATA_W(DATA_W), .MID_W(MID_W), .HI_W(HI_W),
            .LEAD_HP(LEAD_HP), .ALE_HP(ALE_HP), .STB_HP(STB_HP)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .is_internal(is_internal), .hi(hi), .mid(mid), .lo(lo), .wdata(req_wdata),
    .wait_sync(wait_sync), .ad_in(ad_in), .req_ack(req_ack), .int_sel(int_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .ale(ale), .prog_strb(prog_strb),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_mid(addr_mid), .a_hi(addr_hi));

  always_ff @(posedge clk) begin
    if (rst) bus_pin_own <= 1'b0;
    else     bus_pin_own <= port_bus_cfg || !int_rom_en;
  end

  // R11: bus function forced whenever all program space is external
  a_r11_forced_own: assert property (@(posedge clk) disable iff (rst)
    !int_rom_en |=> bus_pin_own);
endmodule

// File: tb/tb_mxb_bus_ctrl.sv
module tb_mxb_bus_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [19:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic [3:0] prog_seg = '0;
  logic int_rom_en = 1'b1, port_bus_cfg = 1'b0, wait_in = 1'b0;
  logic req_ack, int_sel, rd_valid, ad_oe, ale, prog_strb, rd_strb, wr_strb, bus_pin_own;
  logic [7:0] rd_data, ad_out, addr_mid;
  logic [3:0] addr_hi;

  int n_chk = 0, n_fail = 0, cyc = 0;

  mxb_bus_ctrl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model state
  int m_ph = 0, m_len = 2;
  logic [1:0] m_kind;
  logic [7:0] m_lo, m_mid, m_wd, m_rd;
  logic [3:0] m_hi;
  logic w1 = 0, w2 = 0, m_pin = 0;

  always @(posedge clk) begin
    logic ws;
    cyc++;
    ws = w2; w2 = w1; w1 = wait_in;
    if (rst) begin
      m_ph = 0; m_len = 2; m_pin = 0; w1 = 0; w2 = 0; m_rd = 0;
    end else begin
      m_pin = port_bus_cfg | ~int_rom_en;
      if (m_ph == 0) begin
        if (req_valid) begin
          if (req_kind == 2'b00 && int_rom_en && req_addr[19:16] == 4'h0) m_ph = -1;
          else begin
            m_ph = 1; m_len = 2; m_kind = req_kind;
            m_lo = req_addr[7:0]; m_mid = req_addr[15:8]; m_wd = req_wdata;
            m_hi = (req_kind == 2'b00) ? req_addr[19:16] : prog_seg;
          end
        end
      end else if (m_ph == -1) m_ph = 0;
      else if (m_ph == 6 + m_len) m_ph = 0;
      else begin
        if (m_ph == 5 + m_len) begin
          if (m_kind != 2'b00 && ws) m_len++;
          else if (m_kind != 2'b10) m_rd = ad_in;
        end
        m_ph++;
      end
    end
  end

  always begin
    @(posedge clk); #(CLK_P/4);
    if (!rst) begin
      logic st, wr;
      wr = (m_kind == 2'b10);
      st = (m_ph >= 6 && m_ph <= 5 + m_len);
      chk("R4 ale", ale, m_ph == 3 || m_ph == 4);
      chk("R6 ad_oe", ad_oe, (m_ph >= 3 && m_ph <= 5) || (m_ph >= 6 && m_ph <= 6 + m_len && wr));
      if (m_ph >= 3 && m_ph <= 5) chk("R4 low address", ad_out, m_lo);
      if (m_ph >= 6 && wr) chk("R7 write data", ad_out, m_wd);
      if (m_ph > 0) begin
        chk("R4 addr_mid", addr_mid, m_mid);
        chk("R9 addr_hi", addr_hi, m_hi);
      end
      chk("R5 prog_strb", prog_strb, st && m_kind == 2'b00);
      chk("R5 rd_strb", rd_strb, st && (m_kind == 2'b01 || m_kind == 2'b11));
      chk("R5 wr_strb", wr_strb, st && wr);
      chk("R12 req_ack", req_ack, m_ph == -1 || m_ph == 6 + m_len);
      chk("R2 int_sel", int_sel, m_ph == -1);
      chk("R8 rd_valid", rd_valid, m_ph == 6 + m_len && !wr);
      if (m_ph == 6 + m_len && !wr) chk("R8 rd_data", rd_data, m_rd);
      chk("R11 bus_pin_own", bus_pin_own, m_pin);
    end
  end

  // issue one request; wait_in held high for wcyc negedges (0: none)
  task automatic access(input logic [1:0] k, input logic [19:0] a, input logic [7:0] wd,
                        input logic [3:0] seg, input logic [7:0] din, input int wcyc,
                        output int nstb);
    int i = 0;
    nstb = 0;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd; prog_seg = seg; ad_in = din;
    wait_in = (wcyc > 0);
    do begin
      @(negedge clk); i++;
      if (i == wcyc) wait_in = 0;
      if (prog_strb || rd_strb || wr_strb) nstb++;
    end while (!req_ack && i < 200);
    req_valid = 0; wait_in = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 ale", ale, 0); chk("R1 strobes", {prog_strb, rd_strb, wr_strb}, 0);
    chk("R1 ad_oe", ad_oe, 0); chk("R1 ack", {req_ack, rd_valid, int_sel}, 0);
    chk("R1 bus_pin_own", bus_pin_own, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {ale, ad_oe, req_ack, rd_valid, int_sel, bus_pin_own}, 0);

    access(2'b00, 20'h01234, 8'h00, 4'h0, 8'h11, 0, n);
    chk("R2 internal fetch strobes", n, 0);
    access(2'b00, 20'h2ABCD, 8'h00, 4'h0, 8'hA5, 0, n);
    chk("R3 high fetch strobes", n, 2);
    int_rom_en = 0;
    access(2'b00, 20'h00456, 8'h00, 4'h0, 8'h3C, 0, n);
    chk("R3 low fetch external strobes", n, 2);
    access(2'b01, 20'h35A7C, 8'h00, 4'h9, 8'hC3, 0, n);
    chk("R8 read strobes", n, 2);
    access(2'b10, 20'hF1234, 8'h5E, 4'h6, 8'h00, 0, n);
    chk("R7 write strobes", n, 2);
    int_rom_en = 1; port_bus_cfg = 1;
    access(2'b10, 20'h0BEEF, 8'h77, 4'hA, 8'h00, 8, n);
    chk("R10 write stretched", n, 5);
    access(2'b00, 20'h4C0DE, 8'h00, 4'h0, 8'h9A, 8, n);
    chk("R10 fetch not stretched", n, 2);
    port_bus_cfg = 0;
    access(2'b11, 20'h0FF01, 8'h00, 4'hF, 8'h6B, 6, n);
    chk("R10 read stretched", n, 3);
    access(2'b00, 20'h0FFFF, 8'h00, 4'h0, 8'h01, 0, n);
    chk("R2 top internal fetch", n, 0);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule